// File: doc/BRIEF.md
# Programmable Clock Phase Skew Matrix

The block builds four pairs of clock outputs from one fast tick clock. A base output period is N ticks, and N is set by a range select. One time unit of skew is one tick. Each pair is configured by two three-level selects. Depending on the pair, the selects pick a signed phase offset, a divide-by-2 output, a divide-by-4 output or an inverted output. Both outputs of a pair always carry the same waveform.

A phase counter runs modulo N. Each pair output is scheduled as a rising edge at a phase that depends on its function, followed by a high pulse of fixed length. Select and range changes are captured only at the end of a base period. A test select bypasses the tick timing. The outputs then follow a reference input, and each pair keeps its inverting or dividing function.

Top module: `clk_skew_matrix`

## Requirements
- R1: While rst_ni is low, and after the first rising clock edge that follows its release, every bit of q_o is 0.
- R2: Each select is two bits: 00 = low, 01 = mid, 10 = high, and 11 is read as mid. For pair p (p = 0..3), F1 is sel_i[4p+3:4p+2] and F0 is sel_i[4p+1:4p]. Outputs q_o[2p] and q_o[2p+1] are always equal.
- R3: range_i 00 gives N = 44, 01 gives N = 26, 10 gives N = 16, and 11 is read as 01. Let t count ticks, with t = 0 at the second rising edge after reset release. A zero-skew output (F1F0 = mid,mid) is high exactly when t mod N < N/2.
- R4: On pairs 0 and 1, the F1F0 combinations LL, LM, LH, ML, MM, MH, HL, HM, HH give offsets of -4..+4 ticks in that order. An output with offset k is high exactly when (t - k) mod N < N/2, for t >= N.
- R5: On pairs 2 and 3, LM, LH, ML, MM, MH, HL, HM give offsets of -6, -4, -2, 0, +2, +4, +6 ticks, with the same waveform rule as R4.
- R6: LL on pair 2 or pair 3 gives divide-by-2: the output is high exactly when t mod 2N >= N.
- R7: HH on pair 2 gives divide-by-4: the output is high exactly when t mod 4N >= 2N. Its falling edges coincide with the falling edges of divide-by-2.
- R8: HH on pair 3 gives the inverted base clock: the output is high exactly when t mod N >= N/2.
- R9: A change of sel_i or range_i takes effect only at the next base-period boundary. Once started, a high pulse always runs its full length.
- R10: With test_i not 00, each output is derived from ref_i as sampled two ticks earlier:
  - skewed pairs copy that value and the inverted pair complements it;
  - divide-by-2 and divide-by-4 outputs show bit 0 and bit 1 of the count of rising edges of ref_i since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, one time unit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| range_i | input | 2 | Frequency range select (three-level code) |
| test_i | input | 2 | Test select (three-level code); non-low selects reference bypass |
| sel_i | input | 16 | Function selects, four bits per pair (F1 high, F0 low) |
| ref_i | input | 1 | Reference input used in bypass mode |
| q_o | output | 8 | Output pairs; bits 2p and 2p+1 belong to pair p |

## Verification
On every cycle, the assertions check the following:
- the phase counter stays below the active period;
- the period and configuration change only at a period boundary;
- no output produces a single-tick high pulse;
- divided outputs rise only at phase zero;
- in bypass, every divide-by-4 transition coincides with a divide-by-2 fall.

Only the bench scenarios can show the rest. That covers the mapping of each select code to its offset or function, the period chosen by each range code, and the exact placement of every edge over several periods. It also covers the deferred effect of a mid-period select and range change, and the reference-driven waveforms in bypass mode.

// File: rtl/csm_pkg.sv
package csm_pkg;

  typedef enum logic [1:0] {
    FN_SKEW = 2'd0,
    FN_INV  = 2'd1,
    FN_DIV2 = 2'd2,
    FN_DIV4 = 2'd3
  } pair_fn_e;

  typedef struct packed {
    pair_fn_e           fn;
    logic signed [3:0]  off;
  } pair_cfg_t;

  // three-level code to index: low 0, mid 1, high 2; 11 reads as mid
  function automatic int lvl_idx(logic [1:0] v);
    case (v)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/csm_sel_decode.sv
module csm_sel_decode
  import csm_pkg::*;
#(
  parameter int PAIR_IDX = 0
) (
  input  logic [3:0] sel_i,
  output pair_cfg_t  cfg_o
);

  localparam bit DOUBLE_STEP = (PAIR_IDX >= 2);
  localparam bit HH_IS_DIV4  = (PAIR_IDX == 2);

  int code;
  assign code = 3 * lvl_idx(sel_i[3:2]) + lvl_idx(sel_i[1:0]);

  if (DOUBLE_STEP) begin : g_dbl
    always_comb begin
      cfg_o.fn  = FN_SKEW;
      cfg_o.off = 4'sd0;
      if (code == 0) begin
        cfg_o.fn = FN_DIV2;
      end else if (code == 8) begin
        cfg_o.fn = HH_IS_DIV4 ? FN_DIV4 : FN_INV;
      end else begin
        cfg_o.off = 4'(2 * (code - 4));
      end
    end
  end else begin : g_sgl
    always_comb begin
      cfg_o.fn  = FN_SKEW;
      cfg_o.off = 4'(code - 4);
    end
  end

endmodule

// File: rtl/csm_timebase.sv
module csm_timebase
  import csm_pkg::*;
#(
  parameter int NPAIR  = 4,
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16,
  parameter int PW     = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              range_i,
  input  pair_cfg_t [NPAIR-1:0]   cfg_i,
  output logic [PW-1:0]           phase_o,
  output logic [1:0]              cyc_o,
  output logic [PW-1:0]           n_o,
  output logic                    run_o,
  output pair_cfg_t [NPAIR-1:0]   cfg_o
);

  logic [PW-1:0]         phase_q, n_q, n_next;
  logic [1:0]            cyc_q;
  logic                  start_q;
  logic                  wrap;
  pair_cfg_t [NPAIR-1:0] cfg_q;

  always_comb begin
    case (range_i)
      2'b00:   n_next = PW'(N_LOW);
      2'b10:   n_next = PW'(N_HIGH);
      default: n_next = PW'(N_MID);
    endcase
  end

  assign wrap = start_q || (phase_q == n_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      cyc_q   <= '0;
      n_q     <= PW'(N_MID);
      start_q <= 1'b1;
      cfg_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (wrap) begin
        phase_q <= '0;
        n_q     <= n_next;
        cfg_q   <= cfg_i;
        cyc_q   <= start_q ? 2'd0 : cyc_q + 2'd1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign cyc_o   = cyc_q;
  assign n_o     = n_q;
  assign run_o   = !start_q;
  assign cfg_o   = cfg_q;

  // R3
  a_r3_phase_below_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < n_q);

  // R9
  a_r9_period_change_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(n_q) |-> ($past(start_q) || ($past(phase_q) == $past(n_q) - 1'b1)));

endmodule

// File: rtl/csm_pair_out.sv
module csm_pair_out
  import csm_pkg::*;
#(
  parameter int PW = 6,
  parameter int WW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] phase_i,
  input  logic [1:0]    cyc_i,
  input  logic [PW-1:0] n_i,
  input  logic          run_i,
  input  pair_cfg_t     cfg_i,
  output logic          q_o
);

  logic [3:0]    neg_off;
  logic [PW-1:0] kmod;
  logic [WW-1:0] n_ext, width;
  logic          hit;
  logic          q_q;
  logic [WW-1:0] cnt_q;

  assign neg_off = ~cfg_i.off + 4'd1;
  assign n_ext   = WW'(n_i);

  always_comb begin
    if (cfg_i.off[3]) kmod = n_i - {{(PW-4){1'b0}}, neg_off};
    else              kmod = {{(PW-4){1'b0}}, cfg_i.off};
  end

  always_comb begin
    case (cfg_i.fn)
      FN_INV: begin
        hit   = (phase_i == (n_i >> 1));
        width = n_ext >> 1;
      end
      FN_DIV2: begin
        hit   = (phase_i == '0) && cyc_i[0];
        width = n_ext;
      end
      FN_DIV4: begin
        hit   = (phase_i == '0) && (cyc_i == 2'd2);
        width = n_ext << 1;
      end
      default: begin
        hit   = (phase_i == kmod);
        width = n_ext >> 1;
      end
    endcase
  end

  // rise on schedule, then hold high for the full width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else if (q_q) begin
      if (cnt_q == '0) q_q   <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (run_i && hit) begin
      q_q   <= 1'b1;
      cnt_q <= width - 1'b1;
    end
  end

  assign q_o = q_q;

  // R9
  a_r9_no_single_tick_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q) |=> q_q);

  // R6, R7
  a_r6_divided_rise_at_phase0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(q_q) && (cfg_i.fn == FN_DIV2 || cfg_i.fn == FN_DIV4)) |-> ($past(phase_i) == '0));

endmodule

// File: rtl/csm_ref_path.sv
module csm_ref_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic skew_o,
  output logic inv_o,
  output logic div2_o,
  output logic div4_o
);

  logic       ref_s, ref_d, rise;
  logic [1:0] rc_q, rc_n;
  logic       skew_q, inv_q, div2_q, div4_q;

  assign rise = ref_s && !ref_d;
  assign rc_n = rise ? rc_q + 2'd1 : rc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_s  <= 1'b0;
      ref_d  <= 1'b0;
      rc_q   <= '0;
      skew_q <= 1'b0;
      inv_q  <= 1'b0;
      div2_q <= 1'b0;
      div4_q <= 1'b0;
    end else begin
      ref_s  <= ref_i;
      ref_d  <= ref_s;
      rc_q   <= rc_n;
      skew_q <= ref_s;
      inv_q  <= !ref_s;
      div2_q <= rc_n[0];
      div4_q <= rc_n[1];
    end
  end

  assign skew_o = skew_q;
  assign inv_o  = inv_q;
  assign div2_o = div2_q;
  assign div4_o = div4_q;

  // R10, R7
  a_r10_div4_moves_with_div2_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div4_q) |-> $fell(div2_q));

endmodule

// File: rtl/clk_skew_matrix.sv
module clk_skew_matrix
  import csm_pkg::*;
#(
  parameter int NPAIR  = 4,
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         range_i,
  input  logic [1:0]         test_i,
  input  logic [4*NPAIR-1:0] sel_i,
  input  logic               ref_i,
  output logic [2*NPAIR-1:0] q_o
);

  localparam int N_MAX = (N_LOW > N_MID) ? ((N_LOW > N_HIGH) ? N_LOW : N_HIGH)
                                         : ((N_MID > N_HIGH) ? N_MID : N_HIGH);
  localparam int PW = $clog2(N_MAX + 1);
  localparam int WW = $clog2(2 * N_MAX + 1);

  pair_cfg_t [NPAIR-1:0] cfg_raw, cfg_act;
  logic [PW-1:0]         phase, n_cur;
  logic [1:0]            cyc;
  logic                  run;
  logic [NPAIR-1:0]      q_norm;
  logic                  r_skew, r_inv, r_div2, r_div4;
  logic                  test_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) test_on_q <= 1'b0;
    else         test_on_q <= (test_i != 2'b00);
  end

  csm_timebase #(
    .NPAIR(NPAIR), .N_LOW(N_LOW), .N_MID(N_MID), .N_HIGH(N_HIGH), .PW(PW)
  ) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .range_i(range_i), .cfg_i(cfg_raw),
    .phase_o(phase), .cyc_o(cyc), .n_o(n_cur), .run_o(run), .cfg_o(cfg_act)
  );

  csm_ref_path u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i),
    .skew_o(r_skew), .inv_o(r_inv), .div2_o(r_div2), .div4_o(r_div4)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic tq, pq;

    csm_sel_decode #(.PAIR_IDX(p)) u_dec (
      .sel_i(sel_i[4*p +: 4]), .cfg_o(cfg_raw[p])
    );

    csm_pair_out #(.PW(PW), .WW(WW)) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase), .cyc_i(cyc),
      .n_i(n_cur), .run_i(run), .cfg_i(cfg_act[p]), .q_o(q_norm[p])
    );

    always_comb begin
      case (cfg_act[p].fn)
        FN_INV:  tq = r_inv;
        FN_DIV2: tq = r_div2;
        FN_DIV4: tq = r_div4;
        default: tq = r_skew;
      endcase
    end

    assign pq           = test_on_q ? tq : q_norm[p];
    assign q_o[2*p +: 2] = {2{pq}};
  end

endmodule

// File: tb/clk_skew_matrix_test.sv
module clk_skew_matrix_test;

  localparam logic [1:0] LO = 2'b00, MD = 2'b01, HI = 2'b10, IL = 2'b11;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  range_i = 2'b10;
  logic [1:0]  test_i = 2'b00;
  logic [15:0] sel_i = 16'h5555;
  logic        ref_i = 1'b0;
  logic [7:0]  q_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clk_skew_matrix uut (
    .clk_i(clk), .rst_ni(rst_ni), .range_i(range_i), .test_i(test_i),
    .sel_i(sel_i), .ref_i(ref_i), .q_o(q_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int md(int a, int m);
    return ((a % m) + m) % m;
  endfunction

  // kind: 0 skew, 1 invert, 2 div2, 3 div4
  function automatic bit exp_wave(int kind, int k, int n, int t);
    case (kind)
      0:       return md(t - k, n) < n / 2;
      1:       return md(t, n) >= n / 2;
      2:       return md(t, 2 * n) >= n;
      default: return md(t, 4 * n) >= 2 * n;
    endcase
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    test_i  = 2'b00;
    range_i = 2'b10;
    sel_i   = {MD, MD, MD, MD, MD, MD, MD, MD};
    rst_ni  = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(q_o == 8'h00, "R1", "outputs during reset", q_o, 0);
    rst_ni = 1'b1;
    step();
    chk(q_o == 8'h00, "R1", "outputs after first edge", q_o, 0);
    step();
    chk(q_o == 8'hFF, "R3", "zero-skew rise at t=0", q_o, 255);
  endtask

  task automatic run_normal(input string req, input logic [1:0] rng, input int n,
                            input logic [15:0] sel, input int kind [4], input int off [4]);
    int mism [8];
    int first_t [8];
    int first_a [8];
    foreach (mism[i]) begin mism[i] = 0; first_t[i] = -1; first_a[i] = 0; end
    test_i  = 2'b00;
    range_i = rng;
    sel_i   = sel;
    do_reset();
    for (int e = 1; e <= 9 * n + 1; e++) begin
      int t;
      step();
      t = e - 2;
      if (t >= n && t < 9 * n) begin
        for (int o = 0; o < 8; o++) begin
          bit ex;
          ex = exp_wave(kind[o / 2], off[o / 2], n, t);
          if (q_o[o] !== ex) begin
            if (mism[o] == 0) begin first_t[o] = t; first_a[o] = int'(q_o[o]); end
            mism[o]++;
          end
        end
      end
    end
    for (int o = 0; o < 8; o++)
      chk(mism[o] == 0, req, $sformatf("q_o[%0d] first bad t=%0d value", o, first_t[o]),
          first_a[o], 1 - first_a[o]);
  endtask

  task automatic t_zero_all();   // R3 R2
    run_normal("R3 R2", 2'b01, 26, {MD, MD, MD, MD, MD, MD, MD, MD}, '{0, 0, 0, 0}, '{0, 0, 0, 0});
  endtask

  task automatic t_offsets_wide();   // R4 R5
    run_normal("R4 R5", 2'b00, 44, {HI, MD, LO, MD, HI, HI, LO, LO}, '{0, 0, 0, 0}, '{-4, 4, -6, 6});
  endtask

  task automatic t_offsets_narrow();   // R4 R5 R2 (11 read as mid)
    run_normal("R4 R5 R2", 2'b10, 16, {HI, LO, MD, LO, IL, HI, LO, HI}, '{0, 0, 0, 0}, '{-2, 1, -2, 4});
  endtask

  task automatic t_dividers();   // R6 R7
    run_normal("R6 R7", 2'b10, 16, {LO, LO, HI, HI, MD, HI, MD, LO}, '{0, 0, 3, 2}, '{-1, 1, 0, 0});
  endtask

  task automatic t_invert_range11();   // R8 R6 R3
    run_normal("R8 R6 R3", 2'b11, 26, {HI, HI, LO, LO, HI, MD, LO, MD}, '{0, 0, 2, 1}, '{-3, 3, 0, 0});
  endtask

  task automatic t_change();   // R9
    int mism [8];
    int first_t [8];
    foreach (mism[i]) begin mism[i] = 0; first_t[i] = -1; end
    test_i  = 2'b00;
    range_i = 2'b10;
    sel_i   = {MD, MD, MD, MD, MD, MD, MD, MD};
    do_reset();
    for (int e = 1; e <= 32 + 88 + 1; e++) begin
      int t;
      step();
      t = e - 2;
      if (t >= 16) begin
        for (int o = 0; o < 8; o++) begin
          bit ex;
          if (t < 32) ex = exp_wave(0, 0, 16, t);
          else        ex = exp_wave(0, (o < 2) ? 4 : 0, 44, t - 32);
          if (q_o[o] !== ex) begin
            if (mism[o] == 0) first_t[o] = t;
            mism[o]++;
          end
        end
      end
      if (t == 21) begin
        range_i = 2'b00;
        sel_i   = {MD, MD, MD, MD, MD, MD, HI, HI};
      end
    end
    for (int o = 0; o < 8; o++)
      chk(mism[o] == 0, "R9", $sformatf("q_o[%0d] deferred change, mismatches from t=%0d", o, first_t[o]),
          mism[o], 0);
  endtask

  task automatic t_test(input logic [1:0] tv);   // R10
    bit refh [100];
    int mism [8];
    int rc;
    foreach (mism[i]) mism[i] = 0;
    foreach (refh[i]) refh[i] = 1'b0;
    rc      = 0;
    test_i  = tv;
    range_i = 2'b10;
    sel_i   = {HI, HI, HI, HI, MD, LO, MD, MD};
    ref_i   = 1'b0;
    do_reset();
    for (int e = 1; e <= 80; e++) begin
      bit rv;
      rv = (e >= 4) && ((e % 6) < 3);
      ref_i   = rv;
      refh[e] = rv;
      step();
      if (e >= 2 && refh[e - 1] && !refh[e - 2]) rc++;
      if (e >= 3) begin
        bit rs;
        bit ex [4];
        rs = refh[e - 1];
        ex[0] = rs;
        ex[1] = rs;
        ex[2] = rc[1];
        ex[3] = !rs;
        for (int o = 0; o < 8; o++)
          if (q_o[o] !== ex[o / 2]) mism[o]++;
      end
    end
    ref_i = 1'b0;
    for (int o = 0; o < 8; o++)
      chk(mism[o] == 0, "R10", $sformatf("q_o[%0d] bypass test=%0d mismatches", o, tv), mism[o], 0);
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_all();
    t_offsets_wide();
    t_offsets_narrow();
    t_dividers();
    t_invert_range11();
    t_change();
    t_test(2'b01);
    t_test(2'b10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule